// File: doc/BRIEF.md
# UART Register File with Character Timer

This block is the processor-facing register set of a classic byte-oriented UART. A host uses one write strobe and one read strobe on a three-bit byte address to reach eight registers: data (transmit on write, receive on read), interrupt enable, interrupt identification, line control, modem control, line status, modem status and scratch. While the divisor-access bit (line control bit 7) is set, offsets 0 and 1 reach the low and high divisor bytes instead.

The serial line is abstracted to a byte stream in each direction. Transmit bytes queue in a holding buffer. A shift slot takes one byte at a time, holds it for one character time, and then presents it on `tx_valid`/`tx_byte` for one cycle. Received bytes arrive on `rx_valid`/`rx_byte` and occupy a receive slot for one character time before they enter the receive buffer. The character time is the 16-bit divisor multiplied by the number of bits in a frame. A parameter sets both buffers to 16 entries or to 1 entry.

Some reads have side effects. Reading the status register clears its error bits. Reading the identification register drops a pending transmit-empty interrupt. Reading the data register pops the oldest received byte. Read data is combinational from the address. Side effects take place at the clock edge that ends the read cycle.

Top module: `uart_regblk`

## Requirements
- R1: After the synchronous reset, line control reads 0x03. Interrupt enable, modem control and scratch read 0x00. Line status reads 0x60. Interrupt identification reads 0x01.
- R2: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. In this state no transmit byte is queued, no receive byte is popped and interrupt enable is left unchanged.
- R3: The character time is D = {high,low} × (5 + 2·LCR[1] + LCR[3] + (LCR[2] ? 2 : 1)). With the transmitter idle, `tx_valid` is high for exactly one cycle, D+2 clock edges after the edge that writes the data register.
- R4: D is latched only when the divisor low byte is written, using the high byte and line control as they are at that moment. Later changes to the high byte or to line control leave D unchanged.
- R5: The transmit buffer holds 16 bytes when DEEP_FIFO=1 and 1 byte otherwise. Bytes leave in write order. A data write to a full buffer that is not being drained in the same cycle overwrites the slot at the write pointer, which is the oldest queued byte, and the pointer does not move.
- R6: Line status bit 5 is 1 while the transmit buffer is empty. Bit 6 is 1 while the buffer is empty and the slot is idle. A data-register write clears both bits and the pending transmit-empty interrupt.
- R7: A byte on `rx_valid` is captured only while the receive slot is idle and is discarded otherwise. A captured byte enters the receive buffer D+1 edges after the capture edge.
- R8: A data-register read returns the oldest received byte and removes it, or returns 0x00 when the buffer is empty. Line status bit 0 is 1 while received bytes remain.
- R9: When a receive completes into a full buffer that is not being read in the same cycle, the byte is dropped and line status bit 1 (overrun) is set.
- R10: A line-status read returns the current value and then clears bits 1 to 4. An overrun arriving in the same cycle still sets bit 1.
- R11: Interrupt identification reads 0x06 when IER[2] is set and any of line status bits 1 to 4 is set. Otherwise it reads 0x04 when IER[0] and data-ready are set. Otherwise it reads 0x02 when IER[1] is set, line status bit 5 is set and a transmit-empty interrupt is pending. Otherwise it reads 0x01. The pending flag is set when the slot loads a byte. It is cleared by reading offset 2, unless a load happens in the same cycle.
- R12: Interrupt enable keeps only bits 3:0, modem control keeps bits 4:0 and scratch keeps all 8 bits. Modem status always reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| tx_valid | output | 1 | One-cycle pulse when a transmitted character completes |
| tx_byte | output | 8 | Byte that has just been transmitted |
| rx_valid | input | 1 | An incoming byte is offered |
| rx_byte | input | 8 | Incoming byte |

## Verification
A corrupted buffer pointer or count shows up as bytes that arrive at `tx_byte` in the wrong order or go missing. It also shows up as a data-ready or overrun bit that is wrong on the very next status read, within a single character time. A wrong character-time latch moves the `tx_valid` pulse away from D+2 edges after the write, so the bench times that gap to the exact cycle. A side-effect flag that fails to clear stays visible on the next status or identification read, one cycle later.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    typedef enum logic [2:0] {
        OFS_DATA = 3'd0,
        OFS_IER  = 3'd1,
        OFS_IIR  = 3'd2,
        OFS_LCR  = 3'd3,
        OFS_MCR  = 3'd4,
        OFS_LSR  = 3'd5,
        OFS_MSR  = 3'd6,
        OFS_SCR  = 3'd7
    } reg_ofs_e;

    localparam logic [7:0] LCR_RST  = 8'h03;
    localparam logic [7:0] IER_KEEP = 8'h0F;
    localparam logic [7:0] MCR_KEEP = 8'h1F;

    localparam int LCR_DLAB_BIT = 7;
    localparam int LCR_PAR_BIT  = 3;
    localparam int LCR_STOP_BIT = 2;
    localparam int LCR_LEN_BIT  = 1;

    localparam int IER_RXD_BIT  = 0;
    localparam int IER_THR_BIT  = 1;
    localparam int IER_LINE_BIT = 2;

    localparam logic [7:0] IIR_IDLE    = 8'h01;
    localparam logic [7:0] IIR_LINE    = 8'h06;
    localparam logic [7:0] IIR_RXDATA  = 8'h04;
    localparam logic [7:0] IIR_TXEMPTY = 8'h02;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } line_err_t;

    // Number of bit times in one frame for the given line control value.
    function automatic logic [3:0] frame_bits(input logic [7:0] lcr);
        logic [3:0] n;
        n = 4'd5;
        if (lcr[LCR_LEN_BIT]) n = n + 4'd2;
        if (lcr[LCR_PAR_BIT]) n = n + 4'd1;
        n = n + (lcr[LCR_STOP_BIT] ? 4'd2 : 4'd1);
        return n;
    endfunction

endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);

    generate
        if (DEPTH == 1) begin : g_single
            logic [W-1:0] slot_q;
            logic         full_q;

            always_ff @(posedge clk) begin
                if (push_i) slot_q <= din_i;
            end

            always_ff @(posedge clk) begin
                if (rst)               full_q <= 1'b0;
                else if (push_i)       full_q <= 1'b1;
                else if (pop_i)        full_q <= 1'b0;
            end

            assign dout_o  = slot_q;
            assign full_o  = full_q;
            assign empty_o = !full_q;
        end else begin : g_ring
            localparam int PTR_W = $clog2(DEPTH);
            localparam int CNT_W = $clog2(DEPTH + 1);

            logic [W-1:0]     mem [DEPTH];
            logic [PTR_W-1:0] head_q, tail_q;
            logic [CNT_W-1:0] cnt_q;
            logic             is_full, is_empty, adv, pop_ok;

            function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
                return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
            endfunction

            assign is_full  = (cnt_q == CNT_W'(DEPTH));
            assign is_empty = (cnt_q == '0);
            assign pop_ok   = pop_i && !is_empty;
            assign adv      = push_i && (!is_full || pop_ok);

            always_ff @(posedge clk) begin
                if (push_i) mem[head_q] <= din_i;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    head_q <= '0;
                    tail_q <= '0;
                    cnt_q  <= '0;
                end else begin
                    if (adv)    head_q <= nxt(head_q);
                    if (pop_ok) tail_q <= nxt(tail_q);
                    case ({adv, pop_ok})
                        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                        default: cnt_q <= cnt_q;
                    endcase
                end
            end

            assign dout_o  = mem[tail_q];
            assign full_o  = is_full;
            assign empty_o = is_empty;
        end
    endgenerate

endmodule

// File: rtl/uart_rf_slot.sv
module uart_rf_slot #(
    parameter int DUR_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [7:0]       din_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [7:0]       dout_o
);

    logic             busy_q;
    logic [DUR_W-1:0] cnt_q;
    logic [7:0]       data_q;

    assign done_o = busy_q && (cnt_q >= dur_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            data_q <= '0;
        end else if (busy_q) begin
            if (done_o) busy_q <= 1'b0;
            else        cnt_q  <= cnt_q + DUR_W'(1);
        end else if (load_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            data_q <= din_i;
        end
    end

    assign busy_o = busy_q;
    assign dout_o = data_q;

endmodule

// File: rtl/uart_regblk.sv
module uart_regblk
    import uart_rf_pkg::*;
#(
    parameter bit DEEP_FIFO = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte
);

    localparam int DEPTH = DEEP_FIFO ? 16 : 1;
    localparam int DIV_W = 16;
    localparam int DUR_W = DIV_W + 4;

    logic [7:0]       ier_q, lcr_q, mcr_q, scr_q, dll_q, dlh_q;
    logic [DUR_W-1:0] dur_q;
    line_err_t        err_q;
    logic             thre_pend_q, tx_valid_q;
    logic [7:0]       tx_byte_q;

    logic dlab;
    logic wr_thr, wr_dll, wr_dlh, wr_ier, wr_lcr, wr_mcr, wr_scr;
    logic rd_iir, rd_lsr, rx_pop;

    logic       txq_empty, txq_full, tx_load, tx_busy, tx_done;
    logic [7:0] txq_head, tx_shift;
    logic       rxq_empty, rxq_full, rx_load, rx_busy, rx_done, rx_push, rx_overrun;
    logic [7:0] rxq_head, rx_shift;

    logic [7:0] lsr_val, iir_val;
    logic       thre, temt, dr;

    assign dlab = lcr_q[LCR_DLAB_BIT];

    // Address decode
    always_comb begin
        wr_thr = 1'b0; wr_dll = 1'b0; wr_dlh = 1'b0; wr_ier = 1'b0;
        wr_lcr = 1'b0; wr_mcr = 1'b0; wr_scr = 1'b0;
        if (bus_wr) begin
            case (reg_ofs_e'(bus_addr))
                OFS_DATA: if (dlab) wr_dll = 1'b1; else wr_thr = 1'b1;
                OFS_IER:  if (dlab) wr_dlh = 1'b1; else wr_ier = 1'b1;
                OFS_LCR:  wr_lcr = 1'b1;
                OFS_MCR:  wr_mcr = 1'b1;
                OFS_SCR:  wr_scr = 1'b1;
                default:  ;
            endcase
        end
    end

    assign rd_iir = bus_rd && (reg_ofs_e'(bus_addr) == OFS_IIR);
    assign rd_lsr = bus_rd && (reg_ofs_e'(bus_addr) == OFS_LSR);
    assign rx_pop = bus_rd && (reg_ofs_e'(bus_addr) == OFS_DATA) && !dlab && !rxq_empty;

    // Transmit path
    assign tx_load = !tx_busy && !txq_empty;

    uart_rf_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst(rst),
        .push_i(wr_thr), .din_i(bus_wdata), .pop_i(tx_load),
        .dout_o(txq_head), .empty_o(txq_empty), .full_o(txq_full)
    );

    uart_rf_slot #(.DUR_W(DUR_W)) u_txslot (
        .clk(clk), .rst(rst),
        .load_i(tx_load), .din_i(txq_head), .dur_i(dur_q),
        .busy_o(tx_busy), .done_o(tx_done), .dout_o(tx_shift)
    );

    // Receive path
    assign rx_load    = rx_valid && !rx_busy;
    assign rx_push    = rx_done && (!rxq_full || rx_pop);
    assign rx_overrun = rx_done && rxq_full && !rx_pop;

    uart_rf_slot #(.DUR_W(DUR_W)) u_rxslot (
        .clk(clk), .rst(rst),
        .load_i(rx_load), .din_i(rx_byte), .dur_i(dur_q),
        .busy_o(rx_busy), .done_o(rx_done), .dout_o(rx_shift)
    );

    uart_rf_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst(rst),
        .push_i(rx_push), .din_i(rx_shift), .pop_i(rx_pop),
        .dout_o(rxq_head), .empty_o(rxq_empty), .full_o(rxq_full)
    );

    // Register state
    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q       <= '0;
            lcr_q       <= LCR_RST;
            mcr_q       <= '0;
            scr_q       <= '0;
            dll_q       <= '0;
            dlh_q       <= '0;
            dur_q       <= '0;
            err_q       <= '0;
            thre_pend_q <= 1'b0;
            tx_valid_q  <= 1'b0;
            tx_byte_q   <= '0;
        end else begin
            if (wr_ier) ier_q <= bus_wdata & IER_KEEP;
            if (wr_lcr) lcr_q <= bus_wdata;
            if (wr_mcr) mcr_q <= bus_wdata & MCR_KEEP;
            if (wr_scr) scr_q <= bus_wdata;
            if (wr_dlh) dlh_q <= bus_wdata;
            if (wr_dll) begin
                dll_q <= bus_wdata;
                dur_q <= DUR_W'({dlh_q, bus_wdata}) * DUR_W'(frame_bits(lcr_q));
            end

            if (rd_lsr)     err_q     <= '0;
            if (rx_overrun) err_q.ovr <= 1'b1;

            if (wr_thr)       thre_pend_q <= 1'b0;
            else if (tx_load) thre_pend_q <= 1'b1;
            else if (rd_iir)  thre_pend_q <= 1'b0;

            tx_valid_q <= tx_done;
            if (tx_done) tx_byte_q <= tx_shift;
        end
    end

    // Status and identification
    assign thre    = txq_empty;
    assign temt    = txq_empty && !tx_busy;
    assign dr      = !rxq_empty;
    assign lsr_val = {1'b0, temt, thre, err_q.brk, err_q.frm, err_q.par, err_q.ovr, dr};

    always_comb begin
        if (ier_q[IER_LINE_BIT] && (err_q != '0))
            iir_val = IIR_LINE;
        else if (ier_q[IER_RXD_BIT] && dr)
            iir_val = IIR_RXDATA;
        else if (ier_q[IER_THR_BIT] && thre && thre_pend_q)
            iir_val = IIR_TXEMPTY;
        else
            iir_val = IIR_IDLE;
    end

    always_comb begin
        case (reg_ofs_e'(bus_addr))
            OFS_DATA: bus_rdata = dlab ? dll_q : (rxq_empty ? 8'h00 : rxq_head);
            OFS_IER:  bus_rdata = dlab ? dlh_q : ier_q;
            OFS_IIR:  bus_rdata = iir_val;
            OFS_LCR:  bus_rdata = lcr_q;
            OFS_MCR:  bus_rdata = mcr_q;
            OFS_LSR:  bus_rdata = lsr_val;
            OFS_MSR:  bus_rdata = 8'h00;
            OFS_SCR:  bus_rdata = scr_q;
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign tx_valid = tx_valid_q;
    assign tx_byte  = tx_byte_q;

endmodule

// File: rtl/uart_regblk_chk.sv
module uart_regblk_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [2:0] bus_addr,
    input logic       dlab,
    input logic       tx_valid,
    input logic       tx_busy,
    input logic       tx_load,
    input logic       txq_full,
    input logic       thre_pend,
    input logic [7:0] lsr_val,
    input logic       rx_done,
    input logic       rxq_full,
    input logic       rx_pop
);

    // R3
    tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> !tx_valid);

    // R3
    tx_origin_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(tx_busy));

    // R5
    tx_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0 && !dlab && txq_full && !tx_load) |=> txq_full);

    // R6
    thr_write_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0 && !dlab) |=> (!lsr_val[5] && !lsr_val[6] && !thre_pend));

    // R9
    overrun_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rxq_full && !rx_pop) |=> lsr_val[1]);

    // R10
    lsr_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd5 && !(rx_done && rxq_full && !rx_pop)) |=> (lsr_val[4:1] == 4'b0));

    // R11
    iir_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd2 && !tx_load) |=> !thre_pend);

endmodule

bind uart_regblk uart_regblk_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .dlab(dlab), .tx_valid(tx_valid), .tx_busy(tx_busy), .tx_load(tx_load),
    .txq_full(txq_full), .thre_pend(thre_pend_q), .lsr_val(lsr_val),
    .rx_done(rx_done), .rxq_full(rxq_full), .rx_pop(rx_pop)
);

// File: tb/sim_uart_regblk.sv
`timescale 1ns/1ps
module sim_uart_regblk;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] txlog [32];
    int txn = 0;

    always #4 clk = ~clk;

    uart_regblk #(.DEEP_FIFO(1'b1)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    always @(negedge clk) begin
        if (!rst && tx_valid && txn < 32) begin
            txlog[txn] = tx_byte;
            txn = txn + 1;
        end
    end

    // {is_write, offset, write data, expected read}
    localparam int NV = 24;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 3'd3, 8'h00, 8'h03},  // R1 line control reset value
        {1'b0, 3'd1, 8'h00, 8'h00},  // R1
        {1'b0, 3'd5, 8'h00, 8'h60},  // R1 status
        {1'b0, 3'd2, 8'h00, 8'h01},  // R1 identification
        {1'b0, 3'd7, 8'h00, 8'h00},  // R1
        {1'b0, 3'd4, 8'h00, 8'h00},  // R1
        {1'b0, 3'd6, 8'h00, 8'h00},  // R12 modem status
        {1'b0, 3'd0, 8'h00, 8'h00},  // R8 empty read
        {1'b1, 3'd1, 8'hFF, 8'h00},
        {1'b0, 3'd1, 8'h00, 8'h0F},  // R12 enable mask
        {1'b1, 3'd4, 8'hFF, 8'h00},
        {1'b0, 3'd4, 8'h00, 8'h1F},  // R12 modem control mask
        {1'b1, 3'd7, 8'hA5, 8'h00},
        {1'b0, 3'd7, 8'h00, 8'hA5},  // R12 scratch
        {1'b1, 3'd1, 8'h00, 8'h00},
        {1'b1, 3'd3, 8'h83, 8'h00},
        {1'b1, 3'd0, 8'h34, 8'h00},
        {1'b1, 3'd1, 8'h12, 8'h00},
        {1'b0, 3'd0, 8'h00, 8'h34},  // R2 divisor low
        {1'b0, 3'd1, 8'h00, 8'h12},  // R2 divisor high
        {1'b1, 3'd3, 8'h03, 8'h00},
        {1'b0, 3'd1, 8'h00, 8'h00},  // R2 enable untouched
        {1'b0, 3'd5, 8'h00, 8'h60},  // R2 nothing queued
        {1'b0, 3'd3, 8'h00, 8'h03}
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_read(a, v);
        check8(req, v, exp);
    endtask

    task automatic set_divisor(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] lcr);
        bus_write(3'd3, 8'h80 | lcr);
        bus_write(3'd1, hi);
        bus_write(3'd0, lo);
        bus_write(3'd3, lcr);
    endtask

    task automatic tx_measure(input logic [7:0] d, output int n, output logic [7:0] b);
        bus_write(3'd0, d);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!tx_valid && n < 2000);
        b = tx_byte;
    endtask

    task automatic rx_send(input logic [7:0] d, input int gap);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = d;
        @(posedge clk); #1;
        rx_valid = 1'b0;
        repeat (gap) @(posedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] b;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // Table walk: R1 R2 R8 R12
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) bus_write(VEC[i][18:16], VEC[i][15:8]);
            else rd_chk($sformatf("table row %0d (R1/R2/R8/R12)", i), VEC[i][18:16], VEC[i][7:0]);
        end

        // R3: divisor 2, 8-bit frame -> D=16
        set_divisor(8'h00, 8'h02, 8'h03);
        tx_measure(8'h5A, n, b);
        check_int("R3 latency 8-bit frame", n, 18);
        check8("R3 tx byte", b, 8'h5A);
        // R3: parity + 2 stop + long length -> 10 bits, D=20
        set_divisor(8'h00, 8'h02, 8'h0F);
        tx_measure(8'hC1, n, b);
        check_int("R3 latency 10-bit frame", n, 22);
        // R4: change high byte and line control without low write
        bus_write(3'd3, 8'h80);
        bus_write(3'd1, 8'h01);
        bus_write(3'd3, 8'h03);
        tx_measure(8'h77, n, b);
        check_int("R4 duration unchanged without low write", n, 22);

        // R5 / R6: fill and overwrite, D=512
        set_divisor(8'h00, 8'h40, 8'h03);
        txn = 0;
        bus_write(3'd0, 8'd1);
        repeat (3) @(posedge clk);
        for (int k = 2; k <= 18; k++) bus_write(3'd0, 8'(k));
        rd_chk("R6 status while transmitting", 3'd5, 8'h00);
        for (int w = 0; w < 20000 && txn < 17; w++) @(posedge clk);
        repeat (4) @(posedge clk);
        check_int("R5 emitted count", txn, 17);
        check8("R5 first byte", txlog[0], 8'd1);
        check8("R5 overwritten slot", txlog[1], 8'd18);
        for (int k = 2; k < 17; k++)
            check8($sformatf("R5 order idx %0d", k), txlog[k], 8'(k + 1));
        rd_chk("R6 status after drain", 3'd5, 8'h60);
        bus_write(3'd1, 8'h02);
        rd_chk("R11 transmit-empty pending", 3'd2, 8'h02);
        rd_chk("R11 cleared by read", 3'd2, 8'h01);

        // R7: receive timing with D=8
        set_divisor(8'h00, 8'h01, 8'h03);
        bus_write(3'd1, 8'h00);
        rx_send(8'hC3, 8);
        rd_chk("R7 not yet in buffer", 3'd5, 8'h60);
        rd_chk("R7 in buffer after D+1", 3'd5, 8'h61);
        rx_send(8'hC4, 3);
        rx_send(8'hD5, 20);   // slot busy: dropped
        rd_chk("R8 oldest first", 3'd0, 8'hC3);
        rd_chk("R7 second byte", 3'd0, 8'hC4);
        rd_chk("R7 busy byte ignored", 3'd5, 8'h60);

        // R9 / R10 / R11: overrun
        bus_write(3'd1, 8'h05);
        for (int k = 0; k < 16; k++) rx_send(8'(8'h10 + k), 12);
        rx_send(8'hEE, 12);
        rd_chk("R11 line status priority", 3'd2, 8'h06);
        rd_chk("R9 overrun set", 3'd5, 8'h63);
        rd_chk("R10 errors cleared", 3'd5, 8'h61);
        rd_chk("R11 rx data", 3'd2, 8'h04);
        for (int k = 0; k < 16; k++)
            rd_chk($sformatf("R8 pop %0d", k), 3'd0, 8'(8'h10 + k));
        rd_chk("R9 overrun byte dropped", 3'd5, 8'h60);
        rd_chk("R11 idle", 3'd2, 8'h01);

        // R1: reset in mid-operation
        bus_write(3'd7, 8'h77);
        bus_write(3'd0, 8'h99);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        rd_chk("R1 scratch after reset", 3'd7, 8'h00);
        rd_chk("R1 line control after reset", 3'd3, 8'h03);
        rd_chk("R1 status after reset", 3'd5, 8'h60);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule